// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block joins a narrow port A (12 bits by default) to a wide port B. Port B is made of two narrow halves, the low half and the high half. In the A-to-B direction, each half of B has its own storage register with its own active-low load enable. A host can pulse the two enables one after the other. Two narrow words that arrive one after the other from A then sit side by side as one wide word on B. In the B-to-A direction, a select input picks one of the two B input halves. A single narrow register loads the picked half on every clock edge and drives it out on A.

Every control input passes through a register before it acts. These are the two load enables, the half select and the three active-low output enables. A control value sampled on one rising edge therefore takes effect at the next rising edge. Tri-state pins are modelled as three separate signals per port: an input bus, an output bus and a drive flag. Each drive flag comes straight from a registered output enable.

Top module: `bus_exchanger`

## Requirements
- R1: A synchronous active-high reset clears both B half registers and the A register to zero. It also clears all three drive flags, so no port is driven.
- R2: When `ld_lo_n` was sampled low on one rising edge, the low B half register loads `a_in` on the following rising edge. The loaded value is the one present at that later edge.
- R3: When `ld_hi_n` was sampled low on one rising edge, the high B half register loads `a_in` on the following rising edge.
- R4: Driving `ld_lo_n` low for one edge and then `ld_hi_n` low on the next edge presents two successive A words together on B. `{b_hi_out, b_lo_out}` then equals `{second word, first word}`.
- R5: When `pick_hi` was sampled 0 on the previous edge, the A register loads `b_lo_in` on every rising edge.
- R6: When `pick_hi` was sampled 1 on the previous edge, the A register loads `b_hi_in` on every rising edge.
- R7: Each drive flag (`a_drive`, `b_lo_drive`, `b_hi_drive`) is high after an edge exactly when its active-low enable (`a_oe_n`, `b_lo_oe_n`, `b_hi_oe_n`) was low at that edge.
- R8: A control change acts one edge late. If `ld_lo_n` is low only at edge k, the half register takes `a_in` from edge k+1, not from edge k.
- R9: A B half register whose load enable was sampled high keeps its value, whatever `a_in` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 12 | Narrow bus value received from port A |
| a_out | output | 12 | Narrow value driven onto port A (A register) |
| a_drive | output | 1 | High while `a_out` is driven |
| b_lo_in | input | 12 | Low half of the wide bus received from port B |
| b_hi_in | input | 12 | High half of the wide bus received from port B |
| b_lo_out | output | 12 | Low B half register value |
| b_hi_out | output | 12 | High B half register value |
| b_lo_drive | output | 1 | High while `b_lo_out` is driven |
| b_hi_drive | output | 1 | High while `b_hi_out` is driven |
| ld_lo_n | input | 1 | Active-low load enable for the low B half (registered) |
| ld_hi_n | input | 1 | Active-low load enable for the high B half (registered) |
| pick_hi | input | 1 | Half select for the A register: 0 low half, 1 high half (registered) |
| a_oe_n | input | 1 | Active-low output enable for port A (registered) |
| b_lo_oe_n | input | 1 | Active-low output enable for the low B half (registered) |
| b_hi_oe_n | input | 1 | Active-low output enable for the high B half (registered) |

## Verification
Some properties hold on every cycle, and the assertions check those. One is that a half register with its registered enable set takes the value on its input from the previous edge. Another is that a half without its enable stays stable. A third is that the A register follows the half picked on the previous cycle. The last is that each drive flag mirrors the inverted enable one edge later, and that reset leaves everything cleared. Some behaviour can only be shown by the bench's scenarios. These are the one-edge lag seen from the pins, where a word presented at the sampling edge must not be the one captured. Another is the assembly of two successive narrow words into one wide word. The bench also runs randomized control and data against a cycle model that is kept separate from the RTL.

// File: rtl/exch_pkg.sv
package exch_pkg;

  typedef struct packed {
    logic ld_lo;
    logic ld_hi;
    logic pick_hi;
    logic a_en;
    logic b_lo_en;
    logic b_hi_en;
  } exch_ctl_t;

  localparam exch_ctl_t CTL_IDLE = '{default: 1'b0};

endpackage

// File: rtl/exch_ctl_sync.sv
module exch_ctl_sync
  import exch_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ld_lo_n,
  input  logic      ld_hi_n,
  input  logic      pick_hi,
  input  logic      a_oe_n,
  input  logic      b_lo_oe_n,
  input  logic      b_hi_oe_n,
  output exch_ctl_t ctl_q
);

  exch_ctl_t ctl_d;

  always_comb begin
    ctl_d.ld_lo   = ~ld_lo_n;
    ctl_d.ld_hi   = ~ld_hi_n;
    ctl_d.pick_hi = pick_hi;
    ctl_d.a_en    = ~a_oe_n;
    ctl_d.b_lo_en = ~b_lo_oe_n;
    ctl_d.b_hi_en = ~b_hi_oe_n;
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= CTL_IDLE;
    else     ctl_q <= ctl_d;
  end

  // R7: enables appear one edge after sampling, inverted
  a_r7_oe_lag: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (ctl_q.a_en == !$past(a_oe_n)) && (ctl_q.b_lo_en == !$past(b_lo_oe_n))
             && (ctl_q.b_hi_en == !$past(b_hi_oe_n)));

  // R8: load enables lag by one edge
  a_r8_ld_lag: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (ctl_q.ld_lo == !$past(ld_lo_n)) && (ctl_q.ld_hi == !$past(ld_hi_n)));

endmodule

// File: rtl/exch_half_reg.sv
module exch_half_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end

  // R2 / R3: enabled half takes the data present at the edge
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    (!rst && ld) |=> q == $past(d));

  // R9: a half without its enable stays put
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!rst && !ld) |=> $stable(q));

endmodule

// File: rtl/exch_return_reg.sv
module exch_return_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel_hi,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] q
);

  logic [W-1:0] pick;

  always_comb pick = sel_hi ? hi : lo;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= pick;
  end

  // R5: low half followed when select clear
  a_r5_low: assert property (@(posedge clk) disable iff (rst)
    (!rst && !sel_hi) |=> q == $past(lo));

  // R6: high half followed when select set
  a_r6_high: assert property (@(posedge clk) disable iff (rst)
    (!rst && sel_hi) |=> q == $past(hi));

endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger
  import exch_pkg::*;
#(
  parameter int NARROW_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NARROW_W-1:0] a_in,
  output logic [NARROW_W-1:0] a_out,
  output logic                a_drive,
  input  logic [NARROW_W-1:0] b_lo_in,
  input  logic [NARROW_W-1:0] b_hi_in,
  output logic [NARROW_W-1:0] b_lo_out,
  output logic [NARROW_W-1:0] b_hi_out,
  output logic                b_lo_drive,
  output logic                b_hi_drive,
  input  logic                ld_lo_n,
  input  logic                ld_hi_n,
  input  logic                pick_hi,
  input  logic                a_oe_n,
  input  logic                b_lo_oe_n,
  input  logic                b_hi_oe_n
);

  localparam int HALVES = 2;

  exch_ctl_t                          ctl_q;
  logic [HALVES-1:0]                  half_ld;
  logic [HALVES-1:0][NARROW_W-1:0]    half_q;

  exch_ctl_sync u_ctl (
    .clk       (clk),
    .rst       (rst),
    .ld_lo_n   (ld_lo_n),
    .ld_hi_n   (ld_hi_n),
    .pick_hi   (pick_hi),
    .a_oe_n    (a_oe_n),
    .b_lo_oe_n (b_lo_oe_n),
    .b_hi_oe_n (b_hi_oe_n),
    .ctl_q     (ctl_q)
  );

  always_comb half_ld = {ctl_q.ld_hi, ctl_q.ld_lo};

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    exch_half_reg #(.W(NARROW_W)) u_half (
      .clk (clk),
      .rst (rst),
      .ld  (half_ld[h]),
      .d   (a_in),
      .q   (half_q[h])
    );
  end

  exch_return_reg #(.W(NARROW_W)) u_ret (
    .clk    (clk),
    .rst    (rst),
    .sel_hi (ctl_q.pick_hi),
    .lo     (b_lo_in),
    .hi     (b_hi_in),
    .q      (a_out)
  );

  always_comb begin
    b_lo_out   = half_q[0];
    b_hi_out   = half_q[1];
    a_drive    = ctl_q.a_en;
    b_lo_drive = ctl_q.b_lo_en;
    b_hi_drive = ctl_q.b_hi_en;
  end

  // R1: reset leaves ports undriven and data cleared
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> !a_drive && !b_lo_drive && !b_hi_drive
            && (a_out == '0) && (b_lo_out == '0) && (b_hi_out == '0));

endmodule

// File: tb/sim_bus_exchanger.sv
`timescale 1ns/1ps
module sim_bus_exchanger;

  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0, b_lo_in = '0, b_hi_in = '0;
  logic [W-1:0] a_out, b_lo_out, b_hi_out;
  logic         a_drive, b_lo_drive, b_hi_drive;
  logic         ld_lo_n = 1'b1, ld_hi_n = 1'b1, pick_hi = 1'b0;
  logic         a_oe_n = 1'b1, b_lo_oe_n = 1'b1, b_hi_oe_n = 1'b1;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_exchanger #(.NARROW_W(W)) u0 (
    .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .b_lo_in(b_lo_in), .b_hi_in(b_hi_in), .b_lo_out(b_lo_out), .b_hi_out(b_hi_out),
    .b_lo_drive(b_lo_drive), .b_hi_drive(b_hi_drive),
    .ld_lo_n(ld_lo_n), .ld_hi_n(ld_hi_n), .pick_hi(pick_hi),
    .a_oe_n(a_oe_n), .b_lo_oe_n(b_lo_oe_n), .b_hi_oe_n(b_hi_oe_n)
  );

  // bench cycle model
  logic [W-1:0] m_lo, m_hi, m_a;
  logic         m_ld_lo, m_ld_hi, m_sel, m_ae, m_le, m_he;

  function automatic logic [W-1:0] pick_half(logic sel, logic [W-1:0] lo, logic [W-1:0] hi);
    return sel ? hi : lo;
  endfunction

  task automatic model_reset();
    m_lo = '0; m_hi = '0; m_a = '0;
    m_ld_lo = 0; m_ld_hi = 0; m_sel = 0; m_ae = 0; m_le = 0; m_he = 0;
  endtask

  task automatic model_edge();
    if (rst) model_reset();
    else begin
      if (m_ld_lo) m_lo = a_in;
      if (m_ld_hi) m_hi = a_in;
      m_a     = pick_half(m_sel, b_lo_in, b_hi_in);
      m_ld_lo = !ld_lo_n;
      m_ld_hi = !ld_hi_n;
      m_sel   = pick_hi;
      m_ae    = !a_oe_n;
      m_le    = !b_lo_oe_n;
      m_he    = !b_hi_oe_n;
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: inputs already set at negedge; model at posedge; back to negedge
  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic compare_all();
    chk("R2 low half", 32'(b_lo_out), 32'(m_lo));
    chk("R3 high half", 32'(b_hi_out), 32'(m_hi));
    chk(m_sel ? "R6 A reg" : "R5 A reg", 32'(a_out), 32'(m_a));
    chk("R7 drives", {29'd0, a_drive, b_lo_drive, b_hi_drive}, {29'd0, m_ae, m_le, m_he});
  endtask

  initial begin
    logic [W-1:0] w1, w2, keep;
    void'($urandom(32'd4242));
    model_reset();
    @(negedge clk);
    tick(); tick();
    // R1: reset state
    chk("R1 reset data", {8'd0, a_out, b_lo_out[7:0], b_hi_out[3:0]}, 32'd0);
    chk("R1 reset drives", {29'd0, a_drive, b_lo_drive, b_hi_drive}, 32'd0);
    rst = 1'b0;
    a_oe_n = 0; b_lo_oe_n = 0; b_hi_oe_n = 0;
    tick();
    chk("R7 drives on", {29'd0, a_drive, b_lo_drive, b_hi_drive}, 32'd7);

    // R4: two successive words into one wide word
    w1 = 12'h3A5; w2 = 12'hC5E;
    ld_lo_n = 0; tick();              // ld_lo sampled
    a_in = w1; ld_lo_n = 1; ld_hi_n = 0; tick(); // w1 into low, ld_hi sampled
    a_in = w2; ld_hi_n = 1; tick();   // w2 into high
    a_in = 12'h000; tick();
    chk("R4 wide word", {8'd0, b_hi_out, b_lo_out}, {8'd0, w2, w1});

    // R8: value at sampling edge is not the one captured
    a_in = 12'h111; ld_lo_n = 0; tick();
    a_in = 12'h222; ld_lo_n = 1; tick();
    a_in = 12'h333; tick();
    chk("R8 one-edge lag", 32'(b_lo_out), 32'h222);

    // R9: no enable, input churns, half holds
    keep = b_hi_out;
    for (int i = 0; i < 5; i++) begin a_in = W'($urandom); tick(); end
    chk("R9 high half held", 32'(b_hi_out), 32'(keep));
    chk("R9 low half held", 32'(b_lo_out), 32'h222);

    // R5 / R6 directed
    pick_hi = 0; b_lo_in = 12'hABC; b_hi_in = 12'h123; tick(); tick();
    chk("R5 low picked", 32'(a_out), 32'hABC);
    pick_hi = 1; tick(); tick();
    chk("R6 high picked", 32'(a_out), 32'h123);

    // R7: enables off, one edge late
    a_oe_n = 1; tick();
    chk("R7 a drive off", {31'd0, a_drive}, 32'd0);

    // randomized run against the model
    for (int i = 0; i < 2000; i++) begin
      a_in      = W'($urandom);
      b_lo_in   = W'($urandom);
      b_hi_in   = W'($urandom);
      ld_lo_n   = $urandom_range(0, 1) == 1;
      ld_hi_n   = $urandom_range(0, 1) == 1;
      pick_hi   = $urandom_range(0, 1) == 1;
      a_oe_n    = $urandom_range(0, 3) == 0;
      b_lo_oe_n = $urandom_range(0, 3) == 0;
      b_hi_oe_n = $urandom_range(0, 3) == 0;
      tick();
      compare_all();
    end

    // R1 again mid-run
    rst = 1; tick();
    chk("R1 reset after traffic", {8'd0, a_out, b_lo_out[7:0], b_hi_out[3:0]}, 32'd0);
    chk("R1 drives after traffic", {29'd0, a_drive, b_lo_drive, b_hi_drive}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule